// File: doc/BRIEF.md
# Six-Channel Triggered-Update PWM Generator

This block produces six independent pulse-width-modulated levels from one clock. Software programs each channel through a 32-bit register port: a 3-bit prescaler, a 24-bit period count and a 24-bit high-time count. Written values stay in staging registers. The running counters pick them up only when software makes a 0-to-1 transition on the channel's update bit. Clearing that bit afterwards does not stop the channel, so the bit acts purely as an update strobe.

Each channel has a smooth/immediate select. In smooth mode a strobed update waits for the end of the current period and then loads at the period seam. In immediate mode it loads on the next clock and the period restarts. Polarity and the drive style (push-pull or open-drain) act directly, with no strobe. For open-drain pads the block gives a per-channel output enable that is asserted only while the level is low. The register port is a plain single-cycle control interface with no back-pressure. Reads are combinational from the address and writes take effect at the clock edge. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `pwmx_top`

## Requirements
- R1: After reset the control register reads 0x3F3F3F00: update bits [5:0]=0, polarity bits [13:8]=1 (1 = normal), drive bits [21:16]=1 (1 = push-pull), mode bits [29:24]=1 (1 = smooth). Every other register reads 0, every pwm_out is 0 and every pwm_oe is 1.
- R2: The register offsets are: control at 0x00; prescale at 0x04, with channel c in bits [4c+2:4c]; period count at 0x08+8c and high-time count at 0x0C+8c, each 24 bits. Reads return the staged values. Unused bits and unmapped offsets read 0.
- R3: Writes to prescale, period or high-time registers leave a channel's output unchanged until a write turns that channel's update bit from 0 to 1.
- R4: A loaded channel repeats a period of (prescale+1)*period clocks. Each period starts with the active phase, which lasts (prescale+1)*high-time clocks. The smallest valid period count is 2.
- R5: A high-time of 0 keeps the channel inactive for the whole period. A high-time at or above the period count keeps it active.
- R6: In immediate mode (mode bit 0) a strobe loads the staged values on the clock after the control write and restarts the period at its first clock.
- R7: In smooth mode (mode bit 1) a strobe is held pending and the staged values load at the end of the running period, so the old waveform completes.
- R8: Writing a channel's update bit back to 0 neither stops nor alters the running waveform.
- R9: Polarity bit 0 complements the channel's level. This takes effect without a strobe.
- R10: With drive bit 1, pwm_oe stays 1. With drive bit 0 (open-drain), pwm_oe is 1 exactly while pwm_out is 0.
- R11: Programming or strobing one channel does not disturb the timing of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| pwm_out | output | 6 | Per-channel PWM level after polarity |
| pwm_oe | output | 6 | Per-channel pad output enable |

## Verification
On every cycle the assertions check the following properties:
- each channel's counters stay within their active limits;
- active settings change only on a strobe or at a period seam;
- an immediate strobe restarts both counters;
- a pending smooth update survives until the seam;
- a strobe pulse exists only for a real 0-to-1 change of the update bit.

Other behaviour only shows up in the bench's scenarios, which measure the waveform at the pins. These include the period and high-time lengths for random settings, the constant-level extremes, and the exact seam where a smooth update lands. They also cover the inversion and open-drain enable, the survival of the waveform when the update bit is cleared, and the independence of neighbouring channels.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  // register byte offsets
  localparam int CTRL_OFS  = 'h00;
  localparam int PRE_OFS   = 'h04;
  localparam int PER_BASE  = 'h08;
  localparam int DUTY_BASE = 'h0C;
  localparam int CH_STRIDE = 8;
  // control field positions, one 8-bit lane per field
  localparam int UPD_LSB   = 0;
  localparam int POL_LSB   = 8;
  localparam int DRV_LSB   = 16;
  localparam int MODE_LSB  = 24;
  localparam int PRE_SLOT  = 4;
  localparam int MAX_CH    = 8;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NUM_CH-1:0][PRE_W-1:0]    stg_pre,
  output logic [NUM_CH-1:0][CNT_W-1:0]    stg_per,
  output logic [NUM_CH-1:0][CNT_W-1:0]    stg_duty,
  output logic [NUM_CH-1:0]               pol_norm,
  output logic [NUM_CH-1:0]               push_pull,
  output logic [NUM_CH-1:0]               smooth,
  output logic [NUM_CH-1:0]               strobe
);
  logic [NUM_CH-1:0] upd_q;
  logic              ctrl_wr;
  logic              unused_wdata;

  assign ctrl_wr      = wr_en && (addr == ADDR_W'(CTRL_OFS));
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q     <= '0;
      pol_norm  <= '1;
      push_pull <= '1;
      smooth    <= '1;
      strobe    <= '0;
      stg_pre   <= '0;
      stg_per   <= '0;
      stg_duty  <= '0;
    end else begin
      strobe <= ctrl_wr ? (wr_data[UPD_LSB +: NUM_CH] & ~upd_q) : '0;
      if (ctrl_wr) begin
        upd_q     <= wr_data[UPD_LSB  +: NUM_CH];
        pol_norm  <= wr_data[POL_LSB  +: NUM_CH];
        push_pull <= wr_data[DRV_LSB  +: NUM_CH];
        smooth    <= wr_data[MODE_LSB +: NUM_CH];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && addr == ADDR_W'(PRE_OFS))
          stg_pre[c] <= wr_data[PRE_SLOT*c +: PRE_W];
        if (wr_en && addr == ADDR_W'(PER_BASE + CH_STRIDE*c))
          stg_per[c] <= wr_data[CNT_W-1:0];
        if (wr_en && addr == ADDR_W'(DUTY_BASE + CH_STRIDE*c))
          stg_duty[c] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_OFS)) begin
      rd_data[UPD_LSB  +: NUM_CH] = upd_q;
      rd_data[POL_LSB  +: NUM_CH] = pol_norm;
      rd_data[DRV_LSB  +: NUM_CH] = push_pull;
      rd_data[MODE_LSB +: NUM_CH] = smooth;
    end
    if (addr == ADDR_W'(PRE_OFS))
      for (int c = 0; c < NUM_CH; c++) rd_data[PRE_SLOT*c +: PRE_W] = stg_pre[c];
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(PER_BASE + CH_STRIDE*c))  rd_data[CNT_W-1:0] = stg_per[c];
      if (addr == ADDR_W'(DUTY_BASE + CH_STRIDE*c)) rd_data[CNT_W-1:0] = stg_duty[c];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3: a strobe only follows a genuine 0-to-1 change of the update bit
    assert_strobe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[g] |-> (upd_q[g] && !$past(upd_q[g])));
  end
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             smooth,
  input  logic             pol_norm,
  input  logic             push_pull,
  input  logic [PRE_W-1:0] stg_pre,
  input  logic [CNT_W-1:0] stg_per,
  input  logic [CNT_W-1:0] stg_duty,
  output logic             pwm,
  output logic             oe
);
  logic [PRE_W-1:0] a_pre, pre_cnt;
  logic [CNT_W-1:0] a_per, a_duty, per_cnt;
  logic             pending, tick, wrap, load_now, load_seam, active;

  assign tick      = (pre_cnt == a_pre);
  assign wrap      = tick && (({1'b0, per_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, a_per});
  assign load_now  = strobe && !smooth;
  assign load_seam = wrap && (pending || (strobe && smooth));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_pre   <= '0;
      a_per   <= '0;
      a_duty  <= '0;
      pre_cnt <= '0;
      per_cnt <= '0;
      pending <= 1'b0;
    end else if (load_now) begin
      a_pre   <= stg_pre;
      a_per   <= stg_per;
      a_duty  <= stg_duty;
      pre_cnt <= '0;
      per_cnt <= '0;
      pending <= 1'b0;
    end else begin
      if (tick) begin
        pre_cnt <= '0;
        per_cnt <= wrap ? '0 : per_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (load_seam) begin
        a_pre   <= stg_pre;
        a_per   <= stg_per;
        a_duty  <= stg_duty;
        pending <= 1'b0;
      end else if (strobe) begin
        pending <= 1'b1;
      end
    end
  end

  assign active = (per_cnt < a_duty);
  assign pwm    = pol_norm ? active : !active;
  assign oe     = push_pull || !pwm;

  // R4: counters never leave the active limits
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_per >= CNT_W'(2)) |-> (per_cnt < a_per));
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= a_pre);
  // R3: settings hold without a strobe or a seam
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !wrap) |=> ($stable(a_pre) && $stable(a_per) && $stable(a_duty)));
  // R6: immediate strobe restarts the period
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !smooth) |=> (per_cnt == '0 && pre_cnt == '0));
  // R7: a pending smooth update waits for the seam
  assert_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !wrap && !strobe) |=> pending);
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [NUM_CH-1:0][PRE_W-1:0] stg_pre;
  logic [NUM_CH-1:0][CNT_W-1:0] stg_per, stg_duty;
  logic [NUM_CH-1:0]            pol_norm, push_pull, smooth, strobe;

  pwmx_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stg_pre(stg_pre), .stg_per(stg_per), .stg_duty(stg_duty),
    .pol_norm(pol_norm), .push_pull(push_pull), .smooth(smooth), .strobe(strobe)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwmx_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .strobe(strobe[g]), .smooth(smooth[g]),
      .pol_norm(pol_norm[g]), .push_pull(push_pull[g]),
      .stg_pre(stg_pre[g]), .stg_per(stg_per[g]), .stg_duty(stg_duty[g]),
      .pwm(pwm_out[g]), .oe(pwm_oe[g])
    );
  end
endmodule

// File: tb/test_pwmx_top.sv
module test_pwmx_top;
  localparam int NCH = 6;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire  [5:0]  pwm_out, pwm_oe;

  pwmx_top i_pwmx_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] ctrl_sh = 32'h3F3F3F00;
  logic [31:0] pre_sh = '0;
  int unsigned t0[NCH];
  int c_pre[NCH], c_per[NCH], c_duty[NCH];
  bit live[NCH];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_high(int pre, int per, int duty);
    return (pre + 1) * ((duty < per) ? duty : per);
  endfunction

  function automatic int exp_len(int pre, int per);
    return (pre + 1) * per;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = a[5:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); addr = a[5:0]; #1; d = rd_data;
  endtask

  task automatic configure(int c, int pre, int per, int duty);
    pre_sh[4*c +: 4] = pre[3:0];
    wr(4, pre_sh);
    wr(8 + 8*c, per);
    wr(12 + 8*c, duty);
    c_pre[c] = pre; c_per[c] = per; c_duty[c] = duty;
  endtask

  task automatic strobe_ch(int c);
    ctrl_sh[c] = 1'b0; wr(0, ctrl_sh);
    ctrl_sh[c] = 1'b1; wr(0, ctrl_sh);
  endtask

  // immediate strobe: records the first clock of the new period
  task automatic strobe_imm(int c);
    strobe_ch(c);
    @(negedge clk);
    t0[c] = cyc; live[c] = 1;
  endtask

  task automatic measure(int c, int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[c]) highs++;
      @(negedge clk);
    end
  endtask

  task automatic wait_seam(int c);
    int unsigned t;
    t = exp_len(c_pre[c], c_per[c]);
    while (((cyc - t0[c]) % t) != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, c, n, pre, per, duty, k, mism, oecnt;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d);      check("R1 ctrl reset", d, 32'h3F3F3F00);
    rd(4, d);      check("R1 prescale reset", d, 0);
    rd(8 + 8*2, d); check("R1 period reset", d, 0);
    check("R1 pwm_out reset", {26'd0, pwm_out}, 0);
    check("R1 pwm_oe reset", {26'd0, pwm_oe}, 32'h3F);

    // R2 register map and readback
    wr(4, 32'hFFFFFFFF); rd(4, d); check("R2 prescale slots", d, 32'h00777777);
    pre_sh = '0; wr(4, 0);
    wr(8 + 8*4, 32'hFFFFFFFF); rd(8 + 8*4, d); check("R2 period width", d, 32'h00FFFFFF);
    wr(12 + 8*1, 32'hAB123456); rd(12 + 8*1, d); check("R2 hightime width", d, 32'h00123456);
    wr(0, ctrl_sh | 32'hC0C0C0C0); rd(0, d); check("R2 ctrl unused bits", d, 32'h3F3F3F00);
    rd(6'h38, d); check("R2 unmapped offset", d, 0);

    // immediate mode on all channels
    ctrl_sh[29:24] = 6'h00; wr(0, ctrl_sh);

    // R5 extremes
    configure(0, 1, 7, 0); strobe_imm(0);
    measure(0, exp_len(1, 7), h); check("R5 zero high-time", h, 0);
    configure(1, 0, 5, 20); strobe_imm(1);
    measure(1, exp_len(0, 5), h); check("R5 high-time above period", h, 5);

    // R4 and R11: random settings with neighbour checks
    for (int it = 0; it < 10; it++) begin
      c = $urandom_range(0, 4);
      pre = $urandom_range(0, 3);
      per = $urandom_range(2, 16);
      duty = $urandom_range(0, per + 2);
      configure(c, pre, per, duty); strobe_imm(c);
      measure(c, exp_len(pre, per), h);
      check("R4 high length", h, exp_high(pre, per, duty));
      check("R4 period start", {31'd0, pwm_out[c]}, (duty > 0) ? 1 : 0);
      n = (c + 1) % 5;
      if (live[n]) begin
        wait_seam(n);
        measure(n, exp_len(c_pre[n], c_per[n]), h);
        check("R11 neighbour unaffected", h, exp_high(c_pre[n], c_per[n], c_duty[n]));
      end
    end

    // R3 staging without strobe; R6 restart on strobe
    configure(0, 0, 12, 6); strobe_imm(0);
    wr(12, 2); wr(8, 4); pre_sh[3:0] = 4'd2; wr(4, pre_sh);
    wait_seam(0);
    measure(0, 12, h); check("R3 staged values ignored", h, 6);
    c_pre[0] = 2; c_per[0] = 4; c_duty[0] = 2;
    strobe_imm(0);
    measure(0, 6, h); check("R6 restart at period start", h, 6);
    measure(0, 6, h); check("R6 remainder inactive", h, 0);

    // R8 clearing the update bit keeps the waveform
    ctrl_sh[0] = 1'b0; wr(0, ctrl_sh);
    wait_seam(0);
    measure(0, 12, h); check("R8 runs after clear", h, 6);
    check("R8 next period start", {31'd0, pwm_out[0]}, 1);

    // R7 smooth update waits for the seam
    configure(3, 0, 10, 10); strobe_imm(3);
    ctrl_sh[27] = 1'b1; wr(0, ctrl_sh);
    wr(12 + 8*3, 0);
    wait_seam(3);
    strobe_ch(3);
    k = 0;
    while (pwm_out[3] && k < 40) begin k++; @(negedge clk); end
    check("R7 old period completes", k, 6);
    check("R7 load at seam", (cyc - t0[3]) % 10, 0);
    measure(3, 10, h); check("R7 new value active", h, 0);

    // R9 polarity
    configure(5, 0, 8, 3); strobe_imm(5);
    measure(5, 8, h); check("R9 normal polarity", h, 3);
    ctrl_sh[13] = 1'b0; wr(0, ctrl_sh);
    wait_seam(5);
    measure(5, 8, h); check("R9 inverted polarity", h, 5);

    // R10 open-drain enable
    ctrl_sh[21] = 1'b0; wr(0, ctrl_sh);
    wait_seam(5);
    mism = 0; oecnt = 0;
    for (int i = 0; i < 8; i++) begin
      if (pwm_oe[5] !== !pwm_out[5]) mism++;
      if (pwm_oe[5]) oecnt++;
      if (pwm_oe[4] !== 1'b1) mism++;
      @(negedge clk);
    end
    check("R10 oe tracks low level", mism, 0);
    check("R10 oe count per period", oecnt, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule